// File: doc/BRIEF.md
# Frame Pixel Grabber Register

This block lets a host pull a raw image out of a 15x15 imaging array one pixel at a time, through a single read/write register. The array streams its pixels after every frame-start strobe. Each pixel arrives with a 7-bit value and its index. The grabber keeps an index counter. At most once per frame it latches the pixel whose index equals that counter and holds it for the host.

A host read returns the held pixel with a valid flag. A read that consumes a valid pixel moves the counter on and arms the grabber for the following frame. A host write, whatever its data, sends the counter back to pixel 0. A full image therefore takes 225 consuming reads, spread over at least 225 frames. After the last pixel has been consumed the grabber stays idle until the next write.

Top module: `pixel_grabber`

## Requirements
- R1: After reset the read data is 0x00 (valid flag clear). The index counter is 0. No pixel is captured before the first frame-start strobe.
- R2: The read data has the valid flag in bit 7 and the captured 7-bit pixel value (0 to 127) in bits 6:0. While the flag is 0, bits 6:0 are 0.
- R3: The grabber arms at a frame-start strobe only if no pixel is held. Once armed, it captures only the pixel whose index equals the counter, and at most one pixel per frame.
- R4: A read while bit 7 is 1 returns the held pixel, clears the flag and adds 1 to the counter. The next pixel is captured in the following frame, not in the frame where the read occurred.
- R5: A read while bit 7 is 0 returns 0x00 and leaves the counter unchanged. The next capture is still at the same index.
- R6: A held pixel that has not been read is kept unchanged across any number of later frames.
- R7: A write clears the held pixel and sets the counter to 0, and its data value is ignored. Capture resumes at pixel 0 with the next frame. A write in the same cycle as a read takes priority over the read.
- R8: Once the pixel at index 224 has been consumed, no further pixel is captured until a write.
- R9: Consecutive consuming reads deliver indices 0 to 224 in order. Index = column*15 + row, so the readout is column-major with 15 pixels per column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle strobe at the start of each image frame |
| pixValid | input | 1 | A streamed pixel is present this cycle |
| pixIndex | input | 8 | Index of the streamed pixel, 0 to 224 |
| pixValue | input | 7 | Value of the streamed pixel |
| regRd | input | 1 | Register read strobe; consumes a valid pixel |
| regWr | input | 1 | Register write strobe; re-arms at pixel 0 |
| regWdata | input | 8 | Write data, ignored |
| regRdata | output | 8 | {valid, pixel value} |

## Verification
The assertions assume a well-formed pixel stream:
- every index is within 0 to 224;
- pixValid is never high in the same cycle as frameStart;
- each index appears at most once per frame.

Under these assumptions, the index counter stepping by one and the held value staying stable are meaningful invariants. The bench streams every index exactly once per frame, in column-major order, starting the cycle after the strobe. Reads and writes are issued between frames, except where a same-cycle read and write is applied on purpose. Every pixel value is a closed-form function of frame number and index, so each capture can be traced to its frame.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;    // host write: index to 0, drop held pixel
    logic advance;  // host consumed a valid pixel
    logic capture;  // latch the streamed pixel
  } pgStrobes_t;

endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import pg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       pixValid,
  input  logic       regRd,
  input  logic       regWr,
  input  logic       holdValid,
  input  logic       indexMatch,
  input  logic       atLast,
  output pgStrobes_t stb
);

  logic armed;
  logic done;
  logic doneNext;

  always_comb begin
    stb.clear   = regWr;
    stb.advance = regRd && holdValid && !regWr;
    stb.capture = armed && !holdValid && pixValid && indexMatch && !regWr;
  end

  always_comb begin
    if (regWr)                    doneNext = 1'b0;
    else if (stb.advance && atLast) doneNext = 1'b1;
    else                          doneNext = done;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= doneNext;
      if (regWr)
        armed <= 1'b0;
      else if (frameStart)
        armed <= !doneNext && (!holdValid || stb.advance) && !stb.capture;
      else if (stb.capture)
        armed <= 1'b0;
    end
  end

  AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture && !frameStart |=> !armed); // R3

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !stb.capture); // R8

  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !armed && !done); // R7

endmodule

// File: rtl/pg_datapath.sv
module pg_datapath
  import pg_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int PIX_W   = 7,
  parameter int NUM_PIX = 225
) (
  input  logic             clk,
  input  logic             rstN,
  input  pgStrobes_t       stb,
  input  logic [IDX_W-1:0] inIndex,
  input  logic [PIX_W-1:0] inValue,
  output logic             holdValid,
  output logic [PIX_W-1:0] holdValue,
  output logic             indexMatch,
  output logic             atLast
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);

  logic [IDX_W-1:0] pixIdx;

  assign indexMatch = (inIndex == pixIdx);
  assign atLast     = (pixIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixIdx    <= '0;
      holdValid <= 1'b0;
      holdValue <= '0;
    end else if (stb.clear) begin
      pixIdx    <= '0;
      holdValid <= 1'b0;
      holdValue <= '0;
    end else begin
      if (stb.advance) begin
        holdValid <= 1'b0;
        holdValue <= '0;
        if (!atLast) pixIdx <= pixIdx + 1'b1;
      end
      if (stb.capture) begin
        holdValid <= 1'b1;
        holdValue <= inValue;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pixIdx <= LAST_IDX); // R9

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (pixIdx == '0) && !holdValid); // R7

  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance && !stb.clear && !atLast |=> pixIdx == IDX_W'($past(pixIdx) + 1'b1)); // R4

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    holdValid && !stb.clear && !stb.advance |=> holdValid && $stable(holdValue)); // R6

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !holdValid |-> holdValue == '0); // R2

endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber
  import pg_pkg::*;
#(
  parameter int COLS  = 15,
  parameter int ROWS  = 15,
  parameter int PIX_W = 7
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         frameStart,
  input  logic                         pixValid,
  input  logic [$clog2(COLS*ROWS)-1:0] pixIndex,
  input  logic [PIX_W-1:0]             pixValue,
  input  logic                         regRd,
  input  logic                         regWr,
  input  logic [PIX_W:0]               regWdata,
  output logic [PIX_W:0]               regRdata
);

  localparam int NUM_PIX = COLS * ROWS;
  localparam int IDX_W   = $clog2(NUM_PIX);

  pgStrobes_t       stb;
  logic             holdValid;
  logic [PIX_W-1:0] holdValue;
  logic             indexMatch;
  logic             atLast;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata;

  pg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .pixValid   (pixValid),
    .regRd      (regRd),
    .regWr      (regWr),
    .holdValid  (holdValid),
    .indexMatch (indexMatch),
    .atLast     (atLast),
    .stb        (stb)
  );

  pg_datapath #(
    .IDX_W   (IDX_W),
    .PIX_W   (PIX_W),
    .NUM_PIX (NUM_PIX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .inIndex    (pixIndex),
    .inValue    (pixValue),
    .holdValid  (holdValid),
    .holdValue  (holdValue),
    .indexMatch (indexMatch),
    .atLast     (atLast)
  );

  assign regRdata = {holdValid, holdValue};

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    regRd && regRdata[PIX_W] |=> !regRdata[PIX_W]); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    regRd && !regWr && !regRdata[PIX_W] && !pixValid |=> !regRdata[PIX_W]); // R5

endmodule

// File: tb/tb_pixel_grabber.sv
module tb_pixel_grabber;

  localparam int COLS = 15;
  localparam int ROWS = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixIndex = '0;
  logic [6:0] pixValue = '0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;

  int checks = 0;
  int errors = 0;
  int frameNo = 0;

  always #2.5 clk = ~clk;

  pixel_grabber dut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
    .pixIndex(pixIndex), .pixValue(pixValue), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [6:0] pv(int fr, int ix);
    return 7'((ix * 7 + fr * 13 + 3) % 128);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic runFrame();
    frameNo++;
    @(negedge clk) frameStart = 1'b1;
    @(negedge clk) frameStart = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        pixValid = 1'b1;
        pixIndex = 8'(c * ROWS + r);
        pixValue = pv(frameNo, c * ROWS + r);
        @(negedge clk);
      end
    end
    pixValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic doRead(output logic [7:0] got);
    @(negedge clk);
    regRd = 1'b1;
    got = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic doWrite(logic [7:0] d, logic withRead);
    @(negedge clk);
    regWr = 1'b1;
    regRd = withRead;
    regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
    regRd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got;
    int fr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", regRdata, 8'h00);

    // R5: empty read returns 0 and does not advance
    doRead(got);
    check("R5 empty read", got, 8'h00);
    runFrame();
    check("R3 R5 capture idx0", regRdata, {1'b1, pv(frameNo, 0)});
    fr = frameNo;

    // R6: unread pixel kept over frames
    runFrame();
    runFrame();
    check("R6 held pixel", regRdata, {1'b1, pv(fr, 0)});

    // R2 R4: read returns pixel, clears flag, next index next frame
    doRead(got);
    check("R2 read format", got, {1'b1, pv(fr, 0)});
    check("R4 flag cleared", regRdata, 8'h00);
    runFrame();
    check("R4 capture idx1", regRdata, {1'b1, pv(frameNo, 1)});

    // R7: write ignores data, resets to idx0
    doWrite(8'hFF, 1'b0);
    check("R7 write clears", regRdata, 8'h00);
    doRead(got);
    check("R7 read after write", got, 8'h00);
    runFrame();
    check("R7 capture idx0", regRdata, {1'b1, pv(frameNo, 0)});
    doRead(got);
    runFrame();
    check("R3 idx1 again", regRdata, {1'b1, pv(frameNo, 1)});

    // R7: write wins over same-cycle read
    doWrite(8'h5A, 1'b1);
    check("R7 write priority", regRdata, 8'h00);
    runFrame();
    check("R7 priority idx0", regRdata, {1'b1, pv(frameNo, 0)});

    // R9: full column-major sweep
    doWrite(8'h00, 1'b0);
    for (int k = 0; k < COLS * ROWS; k++) begin
      runFrame();
      doRead(got);
      check($sformatf("R9 sweep idx %0d", k), got, {1'b1, pv(frameNo, k)});
    end

    // R8: idle after last pixel
    runFrame();
    check("R8 no capture after last", regRdata, 8'h00);
    doRead(got);
    check("R8 read idle", got, 8'h00);
    runFrame();
    check("R8 still idle", regRdata, 8'h00);

    // R7: write re-arms after completion
    doWrite(8'hA5, 1'b0);
    runFrame();
    check("R7 rearm after done", regRdata, {1'b1, pv(frameNo, 0)});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule